// File: doc/BRIEF.md
# Accumulator compare flag generator

This block compares a 36-bit fractional accumulator against a chosen source operand and turns the outcome into a set of condition code flags. It forms the difference destination minus source, and that difference is used only to derive flags. The accumulator is never written back. The destination is given as one 36-bit word made of a 4-bit extension, a 16-bit high word and a 16-bit low word. The source is chosen from five places:

- the other accumulator;
- a 16-bit data register;
- a 16-bit memory word;
- a 5-bit unsigned immediate;
- a signed 16-bit immediate.

A 16-bit or 5-bit source is first aligned into the high-word position of a 36-bit operand.

The block registers the sign (N), zero (Z), overflow (V), borrow (C), extension-in-use (E) and unnormalized (U) flags, plus a sticky limit flag (L). It does so on every cycle that carries a compare strobe. A mode input moves the evaluation of N, Z, V and C to a 32-bit boundary and forces E low in that mode. The enclosing datapath reads the flag outputs one cycle after the strobe.

Top module: `acc_cmp_flags`

## Requirements
- R1: The flag outputs change only on a rising clock edge where `cmp_valid` is 1. On any other edge they hold their previous values, whatever the operand inputs do.
- R2: `src_sel` picks the source operand:
  - 0 selects `alt_acc` unchanged.
  - 1 selects `reg_word`, 2 selects `mem_word` and 4 selects `imm_long`. Each of these is placed in bits 31:16, with bit 15 of the word copied into bits 35:32 and bits 15:0 set to zero.
  - 3 selects `imm_short`, zero-extended into bits 31:16, with all other bits zero.
  - 5, 6 and 7 select an all-zero source.
- R3: With `cc_mode` = 0, `flag_c` is 1 exactly when the 36-bit unsigned subtraction destination minus source borrows out of bit 35, which is when destination < source as unsigned values.
- R4: With `cc_mode` = 0, `flag_n` equals bit 35 of the 36-bit difference, and `flag_z` is 1 exactly when all 36 bits of the difference are zero.
- R5: With `cc_mode` = 0, `flag_v` is 1 exactly when the signed 36-bit subtraction result lies outside the signed 36-bit range.
- R6: With `cc_mode` = 0, `flag_e` is 1 exactly when bits 35 down to 31 of the difference are not all equal. This is the same as the difference falling outside the signed 32-bit range.
- R7: In both modes, `flag_u` is 1 exactly when bits 31 and 30 of the difference are equal.
- R8: `flag_l` becomes 1 on any compare that sets `flag_v`. Once set, it stays 1 until reset.
- R9: With `cc_mode` = 1, N, Z, V and C are computed on bits 31:0 only, with bit 31 as the sign bit and the borrow taken out of bit 31. `flag_e` is 0.
- R10: While `rst_n` is low, all seven flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe; flags are latched at this edge |
| cc_mode | input | 1 | 1 selects 32-bit flag evaluation |
| src_sel | input | 3 | Source operand select (encoding in R2) |
| dst_acc | input | 36 | Destination accumulator {extension, high, low} |
| alt_acc | input | 36 | The other accumulator |
| reg_word | input | 16 | Data register operand |
| mem_word | input | 16 | Memory word operand |
| imm_short | input | 5 | Unsigned immediate 0..31 |
| imm_long | input | 16 | Signed 16-bit immediate |
| flag_n | output | 1 | Sign of the difference |
| flag_z | output | 1 | Difference is zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Borrow |
| flag_e | output | 1 | Extension bits in use |
| flag_u | output | 1 | Difference is unnormalized |
| flag_l | output | 1 | Sticky overflow indicator |

## Verification
The assertions assume that `cmp_valid`, `cc_mode` and `src_sel` carry known values after reset, and that all operand buses are free of X on any cycle where the strobe is high. Every encoding of `src_sel` is defined, so no select value needs to be excluded. The bench drives every input to a defined value on the falling edge and keeps it there until the next falling edge. It sweeps the accumulator source over a 16-value corner set in both modes, sweeps the short immediate over all 32 values, and runs each 16-bit source with values chosen near its sign and range boundaries.

// File: rtl/acc_cmp_pkg.sv
package acc_cmp_pkg;

    typedef enum logic [2:0] {
        SRC_ALT   = 3'd0,
        SRC_REG   = 3'd1,
        SRC_MEM   = 3'd2,
        SRC_IMM5  = 3'd3,
        SRC_IMM16 = 3'd4
    } src_sel_e;

    // Flags derived from one difference
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic e;
        logic u;
    } cmp_flags_t;

    // Registered status: derived flags plus sticky limit
    typedef struct packed {
        cmp_flags_t f;
        logic       l;
    } cmp_state_t;

endpackage

// File: rtl/acc_src_align.sv
module acc_src_align
    import acc_cmp_pkg::*;
#(
    parameter int EXT_W = 4,
    parameter int HI_W  = 16,
    parameter int LO_W  = 16,
    parameter int IMM_W = 5
) (
    input  logic [2:0]                  sel_i,
    input  logic [EXT_W+HI_W+LO_W-1:0]  alt_i,
    input  logic [HI_W-1:0]             reg_i,
    input  logic [HI_W-1:0]             mem_i,
    input  logic [IMM_W-1:0]            imm5_i,
    input  logic [HI_W-1:0]             imm16_i,
    output logic [EXT_W+HI_W+LO_W-1:0]  src_o
);

    localparam int ACC_W = EXT_W + HI_W + LO_W;

    // Place a signed word in the high-word slot, sign-extended, low word zero
    function automatic logic [ACC_W-1:0] place_signed(input logic [HI_W-1:0] w);
        place_signed = {{EXT_W{w[HI_W-1]}}, w, {LO_W{1'b0}}};
    endfunction

    logic [HI_W-1:0] imm5_word;
    assign imm5_word = {{(HI_W-IMM_W){1'b0}}, imm5_i};

    always_comb begin
        case (src_sel_e'(sel_i))
            SRC_ALT:   src_o = alt_i;
            SRC_REG:   src_o = place_signed(reg_i);
            SRC_MEM:   src_o = place_signed(mem_i);
            SRC_IMM5:  src_o = {{EXT_W{1'b0}}, imm5_word, {LO_W{1'b0}}};
            SRC_IMM16: src_o = place_signed(imm16_i);
            default:   src_o = '0;
        endcase
    end

endmodule

// File: rtl/acc_diff_flags.sv
module acc_diff_flags
    import acc_cmp_pkg::*;
#(
    parameter int ACC_W = 36,
    parameter int CC_W  = 32
) (
    input  logic [ACC_W-1:0] dst_i,
    input  logic [ACC_W-1:0] src_i,
    input  logic             cc_mode_i,
    output cmp_flags_t       flags_o
);

    localparam int TOP  = ACC_W - 1;
    localparam int CTOP = CC_W - 1;
    localparam int GUARD = ACC_W - CC_W + 1;

    logic [ACC_W:0] wide_diff;
    logic [CC_W:0]  narrow_diff;
    logic           wide_v;
    logic           narrow_v;
    logic           ext_uniform;
    logic [GUARD-1:0] guard_bits;

    // Widened by one bit so the borrow appears at the top
    assign wide_diff   = {1'b0, dst_i} - {1'b0, src_i};
    assign narrow_diff = {1'b0, dst_i[CTOP:0]} - {1'b0, src_i[CTOP:0]};

    // Overflow: operands of differing sign and result sign differs from destination
    assign wide_v   = (dst_i[TOP]  ^ src_i[TOP])  & (wide_diff[TOP]    ^ dst_i[TOP]);
    assign narrow_v = (dst_i[CTOP] ^ src_i[CTOP]) & (narrow_diff[CTOP] ^ dst_i[CTOP]);

    assign guard_bits  = wide_diff[TOP:CTOP];
    assign ext_uniform = (&guard_bits) | ~(|guard_bits);

    always_comb begin
        flags_o.u = wide_diff[CTOP] ~^ wide_diff[CTOP-1];
        if (cc_mode_i) begin
            flags_o.n = narrow_diff[CTOP];
            flags_o.z = ~(|narrow_diff[CTOP:0]);
            flags_o.v = narrow_v;
            flags_o.c = narrow_diff[CC_W];
            flags_o.e = 1'b0;
        end else begin
            flags_o.n = wide_diff[TOP];
            flags_o.z = ~(|wide_diff[TOP:0]);
            flags_o.v = wide_v;
            flags_o.c = wide_diff[ACC_W];
            flags_o.e = ~ext_uniform;
        end
    end

endmodule

// File: rtl/acc_cmp_flags.sv
module acc_cmp_flags
    import acc_cmp_pkg::*;
#(
    parameter int EXT_W = 4,
    parameter int HI_W  = 16,
    parameter int LO_W  = 16,
    parameter int IMM_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmp_valid,
    input  logic                        cc_mode,
    input  logic [2:0]                  src_sel,
    input  logic [EXT_W+HI_W+LO_W-1:0]  dst_acc,
    input  logic [EXT_W+HI_W+LO_W-1:0]  alt_acc,
    input  logic [HI_W-1:0]             reg_word,
    input  logic [HI_W-1:0]             mem_word,
    input  logic [IMM_W-1:0]            imm_short,
    input  logic [HI_W-1:0]             imm_long,
    output logic                        flag_n,
    output logic                        flag_z,
    output logic                        flag_v,
    output logic                        flag_c,
    output logic                        flag_e,
    output logic                        flag_u,
    output logic                        flag_l
);

    localparam int ACC_W = EXT_W + HI_W + LO_W;
    localparam int CC_W  = HI_W + LO_W;

    logic [ACC_W-1:0] src_aligned;
    cmp_flags_t       calc_flags;
    cmp_state_t       st_d;
    cmp_state_t       st_q;

    acc_src_align #(
        .EXT_W (EXT_W),
        .HI_W  (HI_W),
        .LO_W  (LO_W),
        .IMM_W (IMM_W)
    ) align_i (
        .sel_i   (src_sel),
        .alt_i   (alt_acc),
        .reg_i   (reg_word),
        .mem_i   (mem_word),
        .imm5_i  (imm_short),
        .imm16_i (imm_long),
        .src_o   (src_aligned)
    );

    acc_diff_flags #(
        .ACC_W (ACC_W),
        .CC_W  (CC_W)
    ) diff_i (
        .dst_i     (dst_acc),
        .src_i     (src_aligned),
        .cc_mode_i (cc_mode),
        .flags_o   (calc_flags)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_valid) begin
            st_d.f = calc_flags;
            st_d.l = st_q.l | calc_flags.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_n = st_q.f.n;
    assign flag_z = st_q.f.z;
    assign flag_v = st_q.f.v;
    assign flag_c = st_q.f.c;
    assign flag_e = st_q.f.e;
    assign flag_u = st_q.f.u;
    assign flag_l = st_q.l;

    // R1: without a strobe the status register holds
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(st_q));

    // R4: a zero difference cannot be negative, borrow or overflow
    a_r4_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> (!flag_n && !flag_c && !flag_v));

    // R8: limit flag is sticky
    a_r8_l_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_l |=> flag_l);

    // R8: a latched overflow always shows the limit flag
    a_r8_l_on_v: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |-> flag_l);

    // R9: extension flag is low after a 32-bit mode compare
    a_r9_cc_no_e: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cc_mode) |=> !flag_e);

endmodule

// File: tb/acc_cmp_flags_tb.sv
module acc_cmp_flags_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        cc_mode = 1'b0;
    logic [2:0]  src_sel = 3'd0;
    logic [35:0] dst_acc = '0;
    logic [35:0] alt_acc = '0;
    logic [15:0] reg_word = '0;
    logic [15:0] mem_word = '0;
    logic [4:0]  imm_short = '0;
    logic [15:0] imm_long = '0;
    logic flag_n, flag_z, flag_v, flag_c, flag_e, flag_u, flag_l;

    int tests = 0;
    int fails = 0;
    logic l_model = 1'b0;
    logic [5:0] last_exp = '0;

    always #2 clk = ~clk;

    acc_cmp_flags dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cc_mode(cc_mode),
        .src_sel(src_sel), .dst_acc(dst_acc), .alt_acc(alt_acc),
        .reg_word(reg_word), .mem_word(mem_word), .imm_short(imm_short),
        .imm_long(imm_long), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .flag_e(flag_e), .flag_u(flag_u), .flag_l(flag_l)
    );

    function automatic longint s36(input logic [35:0] x);
        s36 = x[35] ? longint'(x) - (longint'(1) << 36) : longint'(x);
    endfunction

    function automatic longint s32(input logic [31:0] x);
        s32 = x[31] ? longint'(x) - (longint'(1) << 32) : longint'(x);
    endfunction

    function automatic logic [35:0] corner(input int i);
        case (i)
            0:  corner = 36'h0_0000_0000;
            1:  corner = 36'h0_0000_0001;
            2:  corner = 36'h0_7FFF_FFFF;
            3:  corner = 36'h0_8000_0000;
            4:  corner = 36'h7_FFFF_FFFF;
            5:  corner = 36'h8_0000_0000;
            6:  corner = 36'hF_FFFF_FFFF;
            7:  corner = 36'hF_8000_0000;
            8:  corner = 36'hF_7FFF_FFFF;
            9:  corner = 36'h0_4000_0000;
            10: corner = 36'hF_C000_0000;
            11: corner = 36'h0_0001_0000;
            12: corner = 36'h1_0000_0000;
            13: corner = 36'h0_3FFF_0000;
            14: corner = 36'hA_5A5A_5A5A;
            default: corner = 36'h5_A5A5_1234;
        endcase
    endfunction

    // Source operand per the R2 encoding
    function automatic logic [35:0] model_src(input logic [2:0] sel, input logic [35:0] alt,
            input logic [15:0] rw, input logic [15:0] mw, input logic [4:0] i5,
            input logic [15:0] i16);
        case (sel)
            3'd0: model_src = alt;
            3'd1: model_src = longint'(s36({{4{rw[15]}}, rw, 16'h0}));
            3'd2: model_src = {{4{mw[15]}}, mw, 16'h0};
            3'd3: model_src = longint'(i5) * 65536;
            3'd4: model_src = {{4{i16[15]}}, i16, 16'h0};
            default: model_src = '0;
        endcase
    endfunction

    // {n, z, v, c, e, u}
    function automatic logic [5:0] model_flags(input logic [35:0] d, input logic [35:0] s,
            input logic cc);
        logic [35:0] df;
        logic [31:0] d32;
        longint r;
        logic n, z, v, c, e, u;
        df = d - s;
        u  = (df[31] == df[30]);
        if (!cc) begin
            r = s36(d) - s36(s);
            n = s36(df) < 0;
            z = (d == s);
            v = (r > (longint'(1) << 35) - 1) || (r < -(longint'(1) << 35));
            c = d < s;
            e = (s36(df) > 64'sd2147483647) || (s36(df) < -64'sd2147483648);
        end else begin
            d32 = d[31:0] - s[31:0];
            r = s32(d[31:0]) - s32(s[31:0]);
            n = s32(d32) < 0;
            z = (d[31:0] == s[31:0]);
            v = (r > 64'sd2147483647) || (r < -64'sd2147483648);
            c = d[31:0] < s[31:0];
            e = 1'b0;
        end
        model_flags = {n, z, v, c, e, u};
    endfunction

    task automatic check1(input logic got, input logic exp, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic check_flags(input logic [5:0] ex, input logic cc, input string ctx);
        check1(flag_n, ex[5], $sformatf("%s R4/R9 N", ctx));
        check1(flag_z, ex[4], $sformatf("%s R4/R9 Z", ctx));
        check1(flag_v, ex[3], $sformatf("%s R5/R9 V", ctx));
        check1(flag_c, ex[2], $sformatf("%s R3/R9 C", ctx));
        check1(flag_e, ex[1], cc ? $sformatf("%s R9 E", ctx) : $sformatf("%s R6 E", ctx));
        check1(flag_u, ex[0], $sformatf("%s R7 U", ctx));
        check1(flag_l, l_model, $sformatf("%s R8 L", ctx));
    endtask

    // Drive at falling edge, strobe one cycle, sample at the next falling edge
    task automatic run_cmp(input logic [2:0] sel, input logic cc, input logic [35:0] d,
            input logic [35:0] alt, input logic [15:0] rw, input logic [15:0] mw,
            input logic [4:0] i5, input logic [15:0] i16, input string ctx);
        logic [5:0] ex;
        src_sel = sel; cc_mode = cc; dst_acc = d; alt_acc = alt;
        reg_word = rw; mem_word = mw; imm_short = i5; imm_long = i16;
        cmp_valid = 1'b1;
        ex = model_flags(d, model_src(sel, alt, rw, mw, i5, i16), cc);
        @(negedge clk);
        cmp_valid = 1'b0;
        l_model = l_model | ex[3];
        last_exp = ex;
        check_flags(ex, cc, ctx);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmp_valid = 1'b0;
        repeat (2) @(negedge clk);
        l_model = 1'b0;
        last_exp = '0;
        check_flags(6'b0, 1'b0, "R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Accumulator sweep over corner set, both modes (R3..R9)
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_cmp(3'd0, m[0], corner(i), corner(j), 16'h0, 16'h0, 5'd0, 16'h0,
                            $sformatf("acc m%0d d%0d s%0d", m, i, j));

        // R8: sticky limit from a clean start
        do_reset();
        run_cmp(3'd0, 1'b0, 36'h0_0000_0005, 36'h0_0000_0003, 16'h0, 16'h0, 5'd0, 16'h0, "r8_pre");
        check1(flag_l, 1'b0, "R8 L low before overflow");
        run_cmp(3'd0, 1'b0, 36'h7_FFFF_FFFF, 36'hF_FFFF_FFFF, 16'h0, 16'h0, 5'd0, 16'h0, "r8_ovf");
        check1(flag_l, 1'b1, "R8 L set by overflow");
        run_cmp(3'd0, 1'b0, 36'h0_0000_0002, 36'h0_0000_0002, 16'h0, 16'h0, 5'd0, 16'h0, "r8_post");
        check1(flag_l, 1'b1, "R8 L stays after clean compare");
        check1(flag_v, 1'b0, "R8 V clears on clean compare");

        // R9 vs R4: ext-only difference
        run_cmp(3'd0, 1'b0, 36'h1_0000_0000, 36'h0_0000_0000, 16'h0, 16'h0, 5'd0, 16'h0, "r4_ext");
        check1(flag_z, 1'b0, "R4 Z sees extension bits");
        run_cmp(3'd0, 1'b1, 36'h1_0000_0000, 36'h0_0000_0000, 16'h0, 16'h0, 5'd0, 16'h0, "r9_ext");
        check1(flag_z, 1'b1, "R9 Z ignores extension bits");

        // R2: 16-bit sources, aligned equality and general flags
        do_reset();
        for (int s = 1; s <= 4; s++) begin
            if (s == 3) continue;
            for (int k = 0; k < 8; k++) begin
                logic [15:0] w;
                case (k)
                    0: w = 16'h0000; 1: w = 16'h0001; 2: w = 16'h7FFF; 3: w = 16'h8000;
                    4: w = 16'hFFFF; 5: w = 16'h4000; 6: w = 16'hC000; default: w = 16'h1234;
                endcase
                run_cmp(s[2:0], 1'b0, {{4{w[15]}}, w, 16'h0}, 36'h0, w, w, 5'd0, w,
                        $sformatf("R2 sel%0d w%0d eq", s, k));
                check1(flag_z, 1'b1, $sformatf("R2 sel%0d aligned equal w=%h", s, w));
                for (int i = 0; i < 16; i++)
                    run_cmp(s[2:0], i[0], corner(i), 36'h0, w, w, 5'd0, w,
                            $sformatf("R2 sel%0d w%0d d%0d", s, k, i));
            end
        end

        // R2: short immediate, exhaustive
        for (int v = 0; v < 32; v++) begin
            run_cmp(3'd3, 1'b0, longint'(v) * 65536, 36'hF_FFFF_FFFF, 16'hFFFF, 16'hFFFF,
                    v[4:0], 16'hFFFF, $sformatf("R2 imm5 %0d eq", v));
            check1(flag_z, 1'b1, $sformatf("R2 imm5 %0d zero-extended", v));
            for (int i = 0; i < 16; i += 3)
                run_cmp(3'd3, 1'b0, corner(i), 36'h0, 16'h0, 16'h0, v[4:0], 16'h0,
                        $sformatf("R2 imm5 %0d d%0d", v, i));
        end

        // R2: unused selects give a zero source
        for (int s = 5; s < 8; s++) begin
            run_cmp(s[2:0], 1'b0, 36'h0, 36'h1_2345_6789, 16'h1111, 16'h2222, 5'd7, 16'h3333,
                    $sformatf("R2 sel%0d zero", s));
            check1(flag_z, 1'b1, $sformatf("R2 sel%0d zero source", s));
        end

        // R1: operands change without a strobe, flags hold
        run_cmp(3'd0, 1'b0, 36'h0_0000_0001, 36'h0_0000_0002, 16'h0, 16'h0, 5'd0, 16'h0, "R1 setup");
        for (int k = 0; k < 6; k++) begin
            dst_acc = corner(k + 3); alt_acc = corner(k); cc_mode = k[0];
            src_sel = k[2:0];
            @(negedge clk);
            check_flags(last_exp, 1'b0, $sformatf("R1 hold %0d", k));
        end

        finish_run();
    end

endmodule